// File: doc/BRIEF.md
# Write-Protect Register and Write Permission Logic

This block owns the single protection control byte of a 4096-location nonvolatile array and rules on every write that the bus front end wants to commit. Each cycle in which `wr_req` is high it looks at the target address, the offered data byte and the state of the external lock pin. One cycle later it raises either `grant` or `deny`. The top address of the space, 0xFFF, is not array storage. A write to it is a write to the control byte itself.

The control byte holds four live fields. An arm bit must be set before the array may be written. A two-bit zone code selects which upper part of the array is read-only. A seal bit, together with a high lock pin, freezes the control byte so that no bus traffic can change it. The zone protection stays in force for as long as the byte holds it. The current byte is always visible on `ctrl_q` so that the front end can return it on a read of 0xFFF.

Top module: `prot_guard`

## Requirements
- R1: After reset `ctrl_q` is 0x00, and `grant` and `deny` are both low.
- R2: While the arm bit (bit 1) of `ctrl_q` is 0, every write request to an address below 0xFFF is denied.
- R3: The zone code in bits 4:3 of `ctrl_q` protects array addresses as follows. 00 protects none. 01 protects 0xC00–0xFFE. 10 protects 0x800–0xFFE. 11 protects 0x000–0xFFE. A request to a protected address is denied even when the arm bit is set.
- R4: With the arm bit set, a request to an array address outside the protected zone is granted.
- R5: When the control byte is not sealed, a write to 0xFFF is granted even with the arm bit clear, provided it changes no bit other than bit 1.
- R6: When the arm bit is clear, a write to 0xFFF that would change bit 7 or bits 4:3 is denied, and `ctrl_q` stays unchanged.
- R7: Bits 6, 5, 2 and 0 of `ctrl_q` always read 0, whatever data is written.
- R8: When `lock_pin` is high and the seal bit (bit 7) is 1, every write to 0xFFF is denied and `ctrl_q` holds. With `lock_pin` low, register writes follow R5 and R6 alone. Array writes follow R2–R4 whatever the pin state.
- R9: For each cycle with `wr_req` high, exactly one of `grant` and `deny` is high in the following cycle. Both are low in the cycle after a cycle without a request.
- R10: `ctrl_q` changes only as the result of a granted write to 0xFFF. The new value becomes visible in the same cycle as that `grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | A write wants to commit this cycle |
| wr_addr | input | 12 | Target address of the write |
| wr_data | input | 8 | Data byte of the write (used when the address is 0xFFF) |
| lock_pin | input | 1 | External hardware lock input |
| grant | output | 1 | Previous request is permitted |
| deny | output | 1 | Previous request is refused |
| ctrl_q | output | 8 | Current protection control byte |

## Verification
The situation hardest to reach is the hardware freeze. The stimulus has to arm the byte, then write the seal bit through a granted register write, and only then raise the pin. After that, attempted edits must be refused, including arm-only edits that would otherwise always pass. Dropping the pin must restore access. The bench also sweeps every array address under all four zone codes. This pins down the exact zone boundaries at 0x7FF/0x800 and 0xBFF/0xC00.

// File: rtl/prot_pkg.sv
package prot_pkg;
    localparam int DATA_W    = 8;
    localparam int ARM_BIT   = 1;
    localparam int ZONE_LO   = 3;
    localparam int ZONE_HI   = 4;
    localparam int SEAL_BIT  = 7;
    localparam logic [DATA_W-1:0] LIVE_MASK =
        DATA_W'((1 << ARM_BIT) | (1 << ZONE_LO) | (1 << ZONE_HI) | (1 << SEAL_BIT));
    localparam logic [DATA_W-1:0] ARM_MASK = DATA_W'(1 << ARM_BIT);

    typedef enum logic [1:0] {
        ZONE_NONE    = 2'b00,
        ZONE_QUARTER = 2'b01,
        ZONE_HALF    = 2'b10,
        ZONE_ALL     = 2'b11
    } zone_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              grant;
        logic              deny;
    } guard_state_t;
endpackage

// File: rtl/prot_zone.sv
module prot_zone
    import prot_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  zone_e             zone,
    input  logic [ADDR_W-1:0] addr,
    output logic              covered
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (zone)
            ZONE_NONE:    covered = 1'b0;
            ZONE_QUARTER: covered = addr[TOP] & addr[TOP-1];
            ZONE_HALF:    covered = addr[TOP];
            default:      covered = 1'b1;
        endcase
    end
endmodule

// File: rtl/prot_ctrl_upd.sv
module prot_ctrl_upd
    import prot_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frozen,
    output logic              accept,
    output logic [DATA_W-1:0] next_val
);
    logic [DATA_W-1:0] delta;

    always_comb begin
        next_val = wdata & LIVE_MASK;
        delta    = (cur ^ next_val) & ~ARM_MASK;
        accept   = !frozen && (cur[ARM_BIT] || (delta == '0));
    end
endmodule

// File: rtl/prot_guard.sv
module prot_guard
    import prot_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              lock_pin,
    output logic              grant,
    output logic              deny,
    output logic [7:0]        ctrl_q
);
    localparam logic [ADDR_W-1:0] REG_ADDR = '1;

    guard_state_t st_d, st_q;
    logic         is_reg, frozen, covered, accept, ok;
    logic [7:0]   ctrl_next;
    zone_e        zone;

    assign zone = zone_e'(st_q.ctrl[ZONE_HI:ZONE_LO]);

    prot_zone #(.ADDR_W(ADDR_W)) u_zone (
        .zone    (zone),
        .addr    (wr_addr),
        .covered (covered)
    );

    prot_ctrl_upd u_upd (
        .cur      (st_q.ctrl),
        .wdata    (wr_data),
        .frozen   (frozen),
        .accept   (accept),
        .next_val (ctrl_next)
    );

    always_comb begin
        is_reg   = (wr_addr == REG_ADDR);
        frozen   = lock_pin & st_q.ctrl[SEAL_BIT];
        ok       = is_reg ? accept : (st_q.ctrl[ARM_BIT] & ~covered);
        st_d       = st_q;
        st_d.grant = wr_req & ok;
        st_d.deny  = wr_req & ~ok;
        if (wr_req && is_reg && accept) begin
            st_d.ctrl = ctrl_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant  = st_q.grant;
    assign deny   = st_q.deny;
    assign ctrl_q = st_q.ctrl;
endmodule

// File: rtl/prot_guard_chk.sv
module prot_guard_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              lock_pin,
    input logic              grant,
    input logic              deny,
    input logic [7:0]        ctrl_q
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, deny}));
    p_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (grant || deny));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> (!grant && !deny));
    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & 8'h65) == 8'h00);
    p_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr != TOP_ADDR && !ctrl_q[1]) |=> deny);
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr == TOP_ADDR && lock_pin && ctrl_q[7])
            |=> (deny && $stable(ctrl_q)));
    p_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q != $past(ctrl_q)) |-> grant);
endmodule

bind prot_guard prot_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .lock_pin (lock_pin),
    .grant    (grant),
    .deny     (deny),
    .ctrl_q   (ctrl_q)
);

// File: tb/sim_prot_guard.sv
`timescale 1ns/1ps
module sim_prot_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        lock_pin = 1'b0;
    logic        grant, deny;
    logic [7:0]  ctrl_q;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [7:0]  model = 8'h00;

    always #5 clk = ~clk;

    prot_guard u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock_pin(lock_pin), .grant(grant),
        .deny(deny), .ctrl_q(ctrl_q)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit in_zone(logic [1:0] z, logic [11:0] a);
        case (z)
            2'b00:   return 1'b0;
            2'b01:   return a >= 12'hC00;
            2'b10:   return a >= 12'h800;
            default: return 1'b1;
        endcase
    endfunction

    // expected outcome of one request, updating the model
    function automatic bit expect_ok(logic [11:0] a, logic [7:0] d);
        logic [7:0] nv;
        bit ok;
        if (a != 12'hFFF) return model[1] && !in_zone(model[4:3], a);
        nv = d & 8'h9A;
        ok = !(lock_pin && model[7]) && (model[1] || ((model ^ nv) & 8'hFD) == 0);
        if (ok) model = nv;
        return ok;
    endfunction

    task automatic do_write(string req, logic [11:0] a, logic [7:0] d);
        bit ok;
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        ok = expect_ok(a, d);
        @(negedge clk);
        wr_req = 1'b0;
        check(req, {6'd0, grant, deny}, {6'd0, ok, !ok});
        check(req, ctrl_q, model);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ctrl_q, 8'h00);
        check("R1", {6'd0, grant, deny}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {6'd0, grant, deny}, 8'h00);
        // R2: unarmed array writes refused
        for (int a = 0; a < 4095; a += 7) do_write("R2", 12'(a), 8'h55);
        // R5: arm-only edit accepted while unarmed
        do_write("R5", 12'hFFF, 8'h02);
        check("R5", ctrl_q, 8'h02);
        // R3/R4: full sweep under each zone code
        for (int z = 0; z < 4; z++) begin
            do_write("R3", 12'hFFF, 8'h02 | 8'(z << 3));
            for (int a = 0; a < 4095; a++) do_write(z == 0 ? "R4" : "R3", 12'(a), 8'hA5);
        end
        // R6: unarmed field edits refused
        do_write("R6", 12'hFFF, 8'h00);
        check("R6", ctrl_q, 8'h00);
        do_write("R6", 12'hFFF, 8'h08);
        do_write("R6", 12'hFFF, 8'h0A);
        do_write("R6", 12'hFFF, 8'h80);
        check("R6", ctrl_q, 8'h00);
        // R7: reserved bits dropped
        do_write("R5", 12'hFFF, 8'h67);
        check("R7", ctrl_q, 8'h02);
        do_write("R7", 12'hFFF, 8'hFF);
        check("R7", ctrl_q, 8'h9A);
        // R8: sealed and pin high freezes the byte
        lock_pin = 1'b1;
        do_write("R8", 12'hFFF, 8'h02);
        do_write("R8", 12'hFFF, 8'h00);
        do_write("R8", 12'h123, 8'h00);
        check("R8", ctrl_q, 8'h9A);
        lock_pin = 1'b0;
        do_write("R8", 12'hFFF, 8'h82);
        check("R8", ctrl_q, 8'h82);
        lock_pin = 1'b1;
        do_write("R8", 12'h100, 8'h11);
        do_write("R8", 12'hFFE, 8'h11);
        do_write("R8", 12'hFFF, 8'h80);
        check("R8", ctrl_q, 8'h82);
        lock_pin = 1'b0;
        do_write("R10", 12'hFFF, 8'h00);
        check("R10", ctrl_q, 8'h00);
        @(negedge clk);
        check("R9", {6'd0, grant, deny}, 8'h00);
        check("R10", ctrl_q, 8'h00);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(1500000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule